// File: doc/BRIEF.md
# Dual In-Order Graduation Unit

This block sits at the back of an out-of-order execution core. It keeps a circular completion buffer whose entries are allocated in program order. Execution units may fill those entries in any order. Each cycle the unit looks only at the two oldest entries. It commits them in program order, copies their results to the architectural register file through two write ports, and frees their slots.

Exceptions are not handled when an execution unit reports them. An exception flag is stored with the entry's result and is acted on only when that entry becomes the oldest. At that point the entry is dropped without a register write, a redirect to the handler address is raised, and every younger entry is cleared in the same step.

The front end allocates one entry per cycle and receives the slot index as a tag. Execution units return a result by naming that tag.

Top module: `grad_unit`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and neither write port nor `redirect_valid` is asserted.
- R2: An accepted allocation takes the slot named by `alloc_tag`, and tags are handed out in ascending order modulo DEPTH. `alloc_ready` is 0 while DEPTH entries are in flight, and an allocation offered while `alloc_ready` is 0 is ignored.
- R3: Only a completed oldest entry can graduate. A younger entry that completed earlier waits until every older entry has graduated.
- R4: At most two entries graduate per cycle. The second-oldest graduates in the same cycle only if the oldest graduates without an exception and the second-oldest is itself completed without an exception.
- R5: Write port 0 carries the oldest graduating entry's destination and result. Write port 1 carries the second-oldest's. Both appear in the same cycle the entries graduate.
- R6: When both graduating entries name the same destination register, only port 1 (the younger) is enabled, so the younger value wins.
- R7: When the oldest entry is completed with its exception flag set, no register write occurs. `redirect_valid` is 1 and `redirect_addr` equals `exc_vector` in that cycle. From the next cycle the buffer is empty and allocation restarts at the discarded entry's tag.
- R8: An exception flag on the second-oldest entry has no effect while that entry is second. The oldest still graduates alone, and the redirect is raised one cycle later, once the flagged entry has become the oldest.
- R9: In a redirect cycle `alloc_ready` is 0, and both an offered allocation and a completion are discarded.
- R10: A completion naming a slot that holds no allocated entry is ignored. A later allocation of that slot starts out not completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to allocate one entry |
| alloc_dest | input | RA_W | Architectural destination of the new entry |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_tag | output | log2(DEPTH) | Slot the allocation will occupy |
| cmpl_valid | input | 1 | An execution unit returns a result |
| cmpl_tag | input | log2(DEPTH) | Slot being completed |
| cmpl_data | input | DATA_W | Result value |
| cmpl_exc | input | 1 | Result carries an exception |
| exc_vector | input | VEC_W | Exception handler start address |
| wr0_en | output | 1 | Register write, older graduate |
| wr0_addr | output | RA_W | Destination, older graduate |
| wr0_data | output | DATA_W | Value, older graduate |
| wr1_en | output | 1 | Register write, younger graduate |
| wr1_addr | output | RA_W | Destination, younger graduate |
| wr1_data | output | DATA_W | Value, younger graduate |
| redirect_valid | output | 1 | Exception flush and redirect this cycle |
| redirect_addr | output | VEC_W | Redirect target |

## Verification
The bench completes entries out of order. A unit that committed any completed entry, instead of only the head, would write the younger destinations too early. Two graduates sharing a destination catch a port ordering that lets the older value land last. Placing an exception on the second-oldest entry exposes a design that flushes before the oldest has retired, or one that commits the flagged entry in the pair. The bench also offers allocations and completions during the redirect cycle and against empty slots, and fills the buffer to exactly DEPTH entries. A unit with a leaky flush, a stale done bit or an off-by-one full test then shows a wrong tag, a ghost write or a lost entry.

// File: rtl/gu_pkg.sv
package gu_pkg;
    // Outcome of one graduation cycle.
    typedef enum logic [1:0] {
        GK_NONE  = 2'd0,
        GK_ONE   = 2'd1,
        GK_TWO   = 2'd2,
        GK_FLUSH = 2'd3
    } grad_kind_e;
endpackage

// File: rtl/gu_pick.sv
module gu_pick
    import gu_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  logic [PTR_W-1:0] cnt,
    input  logic             done0,
    input  logic             exc0,
    input  logic             done1,
    input  logic             exc1,
    output grad_kind_e       kind
);
    always_comb begin
        if (cnt == '0 || !done0) begin
            kind = GK_NONE;
        end else if (exc0) begin
            kind = GK_FLUSH;
        end else if (cnt >= PTR_W'(2) && done1 && !exc1) begin
            kind = GK_TWO;
        end else begin
            kind = GK_ONE;
        end
    end
endmodule

// File: rtl/gu_wb.sv
module gu_wb
    import gu_pkg::*;
#(
    parameter int RA_W   = 5,
    parameter int DATA_W = 32
) (
    input  grad_kind_e        kind,
    input  logic [RA_W-1:0]   dest0,
    input  logic [DATA_W-1:0] data0,
    input  logic [RA_W-1:0]   dest1,
    input  logic [DATA_W-1:0] data1,
    output logic              wr0_en,
    output logic [RA_W-1:0]   wr0_addr,
    output logic [DATA_W-1:0] wr0_data,
    output logic              wr1_en,
    output logic [RA_W-1:0]   wr1_addr,
    output logic [DATA_W-1:0] wr1_data
);
    always_comb begin
        wr1_en   = (kind == GK_TWO);
        // Older write dropped when the younger one targets the same register.
        wr0_en   = (kind == GK_ONE) || ((kind == GK_TWO) && (dest0 != dest1));
        wr0_addr = dest0;
        wr0_data = data0;
        wr1_addr = dest1;
        wr1_data = data1;
    end
endmodule

// File: rtl/grad_unit.sv
module grad_unit
    import gu_pkg::*;
#(
    parameter int DEPTH  = 16,   // power of two
    parameter int DATA_W = 32,
    parameter int RA_W   = 5,
    parameter int VEC_W  = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [RA_W-1:0]   alloc_dest,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_tag,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_tag,
    input  logic [DATA_W-1:0] cmpl_data,
    input  logic              cmpl_exc,
    input  logic [VEC_W-1:0]  exc_vector,
    output logic              wr0_en,
    output logic [RA_W-1:0]   wr0_addr,
    output logic [DATA_W-1:0] wr0_data,
    output logic              wr1_en,
    output logic [RA_W-1:0]   wr1_addr,
    output logic [DATA_W-1:0] wr1_data,
    output logic              redirect_valid,
    output logic [VEC_W-1:0]  redirect_addr
);
    typedef struct packed {
        logic              valid;
        logic              done;
        logic              exc;
        logic [RA_W-1:0]   dest;
        logic [DATA_W-1:0] data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] idx0, idx1, tail_idx;
    logic [PTR_W-1:0] cnt;
    logic [PTR_W-1:0] head_ptr;
    logic             full;
    grad_kind_e       kind;

    assign idx0     = st_q.head[IDX_W-1:0];
    assign idx1     = idx0 + IDX_W'(1);
    assign tail_idx = st_q.tail[IDX_W-1:0];
    assign cnt      = st_q.tail - st_q.head;
    assign head_ptr = st_q.head;
    assign full     = (cnt == PTR_W'(DEPTH));

    gu_pick #(.PTR_W(PTR_W)) u_pick (
        .cnt   (cnt),
        .done0 (st_q.ent[idx0].done),
        .exc0  (st_q.ent[idx0].exc),
        .done1 (st_q.ent[idx1].done),
        .exc1  (st_q.ent[idx1].exc),
        .kind  (kind)
    );

    gu_wb #(.RA_W(RA_W), .DATA_W(DATA_W)) u_wb (
        .kind     (kind),
        .dest0    (st_q.ent[idx0].dest),
        .data0    (st_q.ent[idx0].data),
        .dest1    (st_q.ent[idx1].dest),
        .data1    (st_q.ent[idx1].data),
        .wr0_en   (wr0_en),
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data)
    );

    assign redirect_valid = (kind == GK_FLUSH);
    assign redirect_addr  = exc_vector;
    assign alloc_ready    = !full && (kind != GK_FLUSH);
    assign alloc_tag      = tail_idx;

    always_comb begin
        st_d = st_q;

        // Result return: only into live slots, never in a flush cycle.
        if (cmpl_valid && (kind != GK_FLUSH) && st_q.ent[cmpl_tag].valid) begin
            st_d.ent[cmpl_tag].done = 1'b1;
            st_d.ent[cmpl_tag].exc  = cmpl_exc;
            st_d.ent[cmpl_tag].data = cmpl_data;
        end

        // In-order retirement.
        unique case (kind)
            GK_ONE: begin
                st_d.ent[idx0].valid = 1'b0;
                st_d.ent[idx0].done  = 1'b0;
                st_d.head            = st_q.head + PTR_W'(1);
            end
            GK_TWO: begin
                st_d.ent[idx0].valid = 1'b0;
                st_d.ent[idx0].done  = 1'b0;
                st_d.ent[idx1].valid = 1'b0;
                st_d.ent[idx1].done  = 1'b0;
                st_d.head            = st_q.head + PTR_W'(2);
            end
            GK_FLUSH: begin
                for (int i = 0; i < DEPTH; i++) begin
                    st_d.ent[i].valid = 1'b0;
                    st_d.ent[i].done  = 1'b0;
                end
                st_d.tail = st_q.head;
            end
            default: ;
        endcase

        // Allocation into the tail slot.
        if (alloc_valid && alloc_ready) begin
            st_d.ent[tail_idx].valid = 1'b1;
            st_d.ent[tail_idx].done  = 1'b0;
            st_d.ent[tail_idx].exc   = 1'b0;
            st_d.ent[tail_idx].dest  = alloc_dest;
            st_d.ent[tail_idx].data  = '0;
            st_d.tail                = st_q.tail + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/gu_checker.sv
module gu_checker #(
    parameter int DEPTH = 16,
    parameter int RA_W  = 5,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] cnt,
    input logic [PTR_W-1:0] head_ptr,
    input logic             alloc_ready,
    input logic             redirect_valid,
    input logic             wr0_en,
    input logic [RA_W-1:0]  wr0_addr,
    input logic             wr1_en,
    input logic [RA_W-1:0]  wr1_addr
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= PTR_W'(DEPTH));

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == PTR_W'(DEPTH)) |-> !alloc_ready);

    assert_pair_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr1_en |=> (head_ptr == $past(head_ptr) + PTR_W'(2)));

    assert_distinct_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && wr1_en) |-> (wr0_addr != wr1_addr));

    assert_flush_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!wr0_en && !wr1_en));

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (cnt == '0));

    assert_flush_blocks_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !alloc_ready);
endmodule

bind grad_unit gu_checker #(.DEPTH(DEPTH), .RA_W(RA_W)) u_gu_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnt            (cnt),
    .head_ptr       (head_ptr),
    .alloc_ready    (alloc_ready),
    .redirect_valid (redirect_valid),
    .wr0_en         (wr0_en),
    .wr0_addr       (wr0_addr),
    .wr1_en         (wr1_en),
    .wr1_addr       (wr1_addr)
);

// File: tb/tb_grad_unit.sv
`timescale 1ns/1ps
module tb_grad_unit;
    localparam int DEPTH = 16;
    localparam int IW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [4:0]  alloc_dest = '0;
    logic        alloc_ready;
    logic [IW-1:0] alloc_tag;
    logic        cmpl_valid = 1'b0;
    logic [IW-1:0] cmpl_tag = '0;
    logic [31:0] cmpl_data = '0;
    logic        cmpl_exc = 1'b0;
    logic [31:0] exc_vector = 32'h8000_0180;
    logic        wr0_en, wr1_en, redirect_valid;
    logic [4:0]  wr0_addr, wr1_addr;
    logic [31:0] wr0_data, wr1_data, redirect_addr;

    always #4 clk = ~clk;

    grad_unit dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
        .cmpl_data(cmpl_data), .cmpl_exc(cmpl_exc),
        .exc_vector(exc_vector),
        .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
    );

    typedef struct {
        int          tag;
        bit          done;
        bit          exc;
        int          dest;
        logic [31:0] data;
    } m_ent_t;

    m_ent_t mq[$];
    int     m_head = 0;
    int     n_checks = 0;
    int     n_fail = 0;
    string  cur_req = "R1";
    bit     finished = 1'b0;

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(bit av, int ad, bit cv, int ct, logic [31:0] cd, bit cx);
        int  n, tail;
        bit  g0, g1, redir, rdy, w0;
        @(negedge clk);
        alloc_valid = av;
        alloc_dest  = ad[4:0];
        cmpl_valid  = cv;
        cmpl_tag    = ct[IW-1:0];
        cmpl_data   = cd;
        cmpl_exc    = cx;
        #1;
        n     = mq.size();
        tail  = (m_head + n) % DEPTH;
        g0    = (n >= 1) && mq[0].done;
        redir = g0 && mq[0].exc;
        g1    = g0 && !mq[0].exc && (n >= 2) && mq[1].done && !mq[1].exc;
        rdy   = (n < DEPTH) && !redir;
        w0    = g0 && !mq[0].exc && !(g1 && mq[0].dest == mq[1].dest);
        chk("alloc_ready", 64'(alloc_ready), 64'(rdy));
        chk("alloc_tag", 64'(alloc_tag), 64'(tail));
        chk("redirect_valid", 64'(redirect_valid), 64'(redir));
        if (redir) chk("redirect_addr", 64'(redirect_addr), 64'(exc_vector));
        chk("wr0_en", 64'(wr0_en), 64'(w0));
        if (w0) begin
            chk("wr0_addr", 64'(wr0_addr), 64'(mq[0].dest));
            chk("wr0_data", 64'(wr0_data), 64'(mq[0].data));
        end
        chk("wr1_en", 64'(wr1_en), 64'(g1));
        if (g1) begin
            chk("wr1_addr", 64'(wr1_addr), 64'(mq[1].dest));
            chk("wr1_data", 64'(wr1_data), 64'(mq[1].data));
        end
        @(posedge clk);
        if (redir) begin
            mq.delete();
        end else begin
            if (g1) begin
                void'(mq.pop_front()); void'(mq.pop_front());
                m_head = (m_head + 2) % DEPTH;
            end else if (g0) begin
                void'(mq.pop_front());
                m_head = (m_head + 1) % DEPTH;
            end
            if (cv) begin
                foreach (mq[i]) begin
                    if (mq[i].tag == ct) begin
                        mq[i].done = 1'b1;
                        mq[i].exc  = cx;
                        mq[i].data = cd;
                    end
                end
            end
        end
        if (av && rdy) begin
            m_ent_t e;
            e.tag = tail; e.done = 1'b0; e.exc = 1'b0; e.dest = ad; e.data = '0;
            mq.push_back(e);
        end
    endtask

    task automatic idle();
        step(1'b0, 0, 1'b0, 0, 32'h0, 1'b0);
    endtask

    task automatic alloc(int d);
        step(1'b1, d, 1'b0, 0, 32'h0, 1'b0);
    endtask

    task automatic cmpl(int t, logic [31:0] v, bit x);
        step(1'b0, 0, 1'b1, t % DEPTH, v, x);
    endtask

    function automatic int tail_now();
        return (m_head + mq.size()) % DEPTH;
    endfunction

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int b;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: idle state after reset
        cur_req = "R1";
        idle();

        // R3/R4/R5: out-of-order completion, head blocks, then a pair retires
        cur_req = "R3";
        b = tail_now();
        alloc(3); alloc(4); alloc(5);
        cmpl(b + 2, 32'hA000_0002, 1'b0);
        cmpl(b + 1, 32'hA000_0001, 1'b0);
        idle();
        cur_req = "R4";
        cmpl(b, 32'hA000_0000, 1'b0);
        cur_req = "R5";
        idle(); idle(); idle();

        // R6: same destination, younger wins
        cur_req = "R6";
        b = tail_now();
        alloc(7); alloc(7);
        cmpl(b, 32'h1111_1111, 1'b0);
        cmpl(b + 1, 32'h2222_2222, 1'b0);
        idle(); idle();

        // R7: exception at the head
        cur_req = "R7";
        exc_vector = 32'hBFC0_0380;
        b = tail_now();
        alloc(1); alloc(2); alloc(3);
        cmpl(b + 1, 32'h0000_0055, 1'b0);
        cmpl(b, 32'h0000_0066, 1'b1);
        idle(); idle();
        alloc(9);
        cmpl(b, 32'h0000_0077, 1'b0);
        idle();

        // R8: exception on second-oldest waits until it is oldest
        cur_req = "R8";
        b = tail_now();
        alloc(10); alloc(11);
        cmpl(b + 1, 32'hDEAD_0001, 1'b1);
        cmpl(b, 32'hC0DE_0000, 1'b0);
        idle(); idle(); idle();

        // R9: allocation and completion during the redirect cycle
        cur_req = "R9";
        b = tail_now();
        alloc(12); alloc(13);
        cmpl(b, 32'h0, 1'b1);
        step(1'b1, 14, 1'b1, (b + 1) % DEPTH, 32'h99, 1'b0);
        idle(); idle();

        // R10: completion to an empty slot is dropped
        cur_req = "R10";
        b = tail_now();
        cmpl(b + 1, 32'h5555_5555, 1'b0);
        alloc(20); alloc(21);
        cmpl(b, 32'h6666_6666, 1'b0);
        idle(); idle();
        cmpl(b + 1, 32'h7777_7777, 1'b0);
        idle();

        // R2: fill to DEPTH, overflow attempt, drain in reverse order
        cur_req = "R2";
        b = tail_now();
        for (int i = 0; i < DEPTH + 1; i++) alloc(i % 32);
        idle();
        for (int i = DEPTH - 1; i >= 0; i--) cmpl(b + i, 32'hF000_0000 + 32'(i), 1'b0);
        repeat (DEPTH / 2 + 2) idle();

        // Mixed traffic against the reference model
        cur_req = "R3/R5";
        for (int c = 0; c < 600; c++) begin
            int cand[$];
            bit av, cv, cx;
            int ct;
            foreach (mq[i]) if (!mq[i].done) cand.push_back(mq[i].tag);
            av = ($urandom % 3) != 0;
            cv = (cand.size() > 0) && (($urandom % 4) != 0);
            ct = cv ? cand[$urandom % cand.size()] : 0;
            cx = ($urandom % 24) == 0;
            step(av, $urandom % 4, cv, ct, $urandom, cx);
        end
        repeat (4) idle();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule